// File: doc/BRIEF.md
# External Interrupt Controller with Grouping

This block takes 28 external interrupt lines. It brings each line into the core clock domain and checks it for one of five trigger conditions. When a line triggers, the block records a pending flag for it. Each line can be blocked by its own mask bit. The pending, unmasked lines are merged into four group interrupt outputs, which feed a downstream vectored controller.

Software reaches the block through a small synchronous register port. The port has four word addresses. Two of them hold the trigger-mode fields, with one 4-bit field shared by each pair of adjacent lines. The third holds the masks and the fourth holds the pending flags, which are cleared by writing 1.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every line is masked (mask reads 0x0FFFFFFF), no pending flag is set, both mode registers read 0 and `irq_o` is 0.
- R2: Register addresses are 0 for the mode register of lines 0..15 (32 bits, all stored), 1 for the mode register of lines 16..27 (bits 23:0 stored, bits 31:24 read 0), 2 for mask and 3 for pending. A write takes effect when `sel_i` and `we_i` are high at a clock edge. `rdata_o` shows the register chosen by `addr_i` combinationally.
- R3: Line n takes its mode from bits [2:0] of the 4-bit field that starts at bit ((n mod 16)/2)*4. That field sits in register 0 when n < 16 and in register 1 otherwise. Lines 2k and 2k+1 share one field, and field bit 3 is stored but has no effect.
- R4: Mode codes (field bits 2:0) are: 000 = low level, 001 = high level, 010 or 011 = falling edge, 100 or 101 = rising edge, 110 or 111 = both edges.
- R5: A line change driven before clock edge k sets the pending flag at edge k+2 (two synchroniser stages, then detection). The flag is not visible after edge k+1.
- R6: In a level mode the flag is set again on every cycle the level is active, so a clear only holds once the synchronised input is inactive.
- R7: Writing address 3 clears each pending flag whose data bit is 1. Data bits that are 0 leave the flag unchanged.
- R8: If a trigger and a clear reach the same flag in one cycle, the flag ends up set.
- R9: A mask bit of 1 blocks its line from the group outputs and 0 lets it through. Pending flags are set regardless of the mask.
- R10: `irq_o[0..3]` is the OR of pending-and-unmasked lines over the ranges 0..3, 4..11, 12..19 and 20..27.
- R11: The mask register stores bits 27:0, and bits 31:28 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 28 | Asynchronous external interrupt lines |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write enable |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 4 | Group interrupt outputs |

## Verification
The bench builds the block with its defaults: 28 lines, two synchroniser stages and a split at 16 lines. With these values the upper mode register carries six fields with eight unused top bits, and all four unequal group boundaries can be exercised. Directed cases cover the exact edge-to-pending latency, level re-assertion against a clear, the shared field of lines 0 and 1, and mask gating. A seeded random phase then toggles lines sparsely and writes random modes, masks and clears, against a cycle model in the bench.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    A_CFG_LO = 2'd0,
    A_CFG_HI = 2'd1,
    A_MASK   = 2'd2,
    A_PEND   = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    TRIG_LOW, TRIG_HIGH, TRIG_FALL, TRIG_RISE, TRIG_BOTH
  } trig_e;

  function automatic trig_e decode_trig(logic [2:0] f);
    casez (f)
      3'b000:  return TRIG_LOW;
      3'b001:  return TRIG_HIGH;
      3'b01?:  return TRIG_FALL;
      3'b10?:  return TRIG_RISE;
      default: return TRIG_BOTH;
    endcase
  endfunction

  // group 0 is 4 lines wide, the rest 8
  function automatic int grp_first(int g);
    return (g == 0) ? 0 : 4 + (g - 1) * 8;
  endfunction

  function automatic int grp_last(int g, int num_groups, int num_lines);
    return (g == num_groups - 1) ? num_lines - 1 : grp_first(g + 1) - 1;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_i,
  input  trig_e mode_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic prev_q, pend_q, hit;

  always_comb begin
    unique case (mode_i)
      TRIG_LOW:  hit = ~sync_i;
      TRIG_HIGH: hit = sync_i;
      TRIG_FALL: hit = prev_q & ~sync_i;
      TRIG_RISE: hit = ~prev_q & sync_i;
      default:   hit = prev_q ^ sync_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      pend_q <= hit | (pend_q & ~clr_i);  // set beats clear
    end
  end

  assign pend_o = pend_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit) |=> pend_q);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !pend_q);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hit) |=> $stable(pend_q));
  p_rise_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_RISE && $rose(sync_i)) |=> pend_q);
  p_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_HIGH && sync_i) |=> pend_q);
endmodule

// File: rtl/ext_irq_group.sv
module ext_irq_group #(
  parameter int W = 8
) (
  input  logic [W-1:0] act_i,
  output logic         irq_o
);
  assign irq_o = |act_i;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES   = 28,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FIELD_W     = 4,
  parameter int LO_LINES    = 16,
  parameter int NUM_GROUPS  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [1:0]           addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  localparam int HI_LINES = NUM_LINES - LO_LINES;
  localparam int HI_BITS  = ((HI_LINES + 1) / 2) * FIELD_W;

  logic [DATA_W-1:0]    cfg_lo_q;
  logic [HI_BITS-1:0]   cfg_hi_q;
  logic [NUM_LINES-1:0] mask_q, pend, clr, sync, act;
  logic                 wr;

  assign wr  = sel_i & we_i;
  assign clr = (wr && addr_i == A_PEND) ? wdata_i[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '1;
    end else if (wr) begin
      unique case (addr_i)
        A_CFG_LO: cfg_lo_q <= wdata_i;
        A_CFG_HI: cfg_hi_q <= wdata_i[HI_BITS-1:0];
        A_MASK:   mask_q   <= wdata_i[NUM_LINES-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CFG_LO: rdata_o = cfg_lo_q;
      A_CFG_HI: rdata_o = DATA_W'(cfg_hi_q);
      A_MASK:   rdata_o = DATA_W'(mask_q);
      default:  rdata_o = DATA_W'(pend);
    endcase
  end

  ext_irq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(line_i), .q_o(sync)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [2:0] fld;
    if (n < LO_LINES) begin : g_lo
      assign fld = cfg_lo_q[(n / 2) * FIELD_W +: 3];
    end else begin : g_hi
      assign fld = cfg_hi_q[((n - LO_LINES) / 2) * FIELD_W +: 3];
    end
    ext_irq_line u_line (
      .clk_i, .rst_ni,
      .sync_i(sync[n]), .mode_i(decode_trig(fld)),
      .clr_i(clr[n]), .pend_o(pend[n])
    );
  end

  assign act = pend & ~mask_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = grp_first(g);
    localparam int HI = grp_last(g, NUM_GROUPS, NUM_LINES);
    ext_irq_group #(.W(HI - LO + 1)) u_grp (.act_i(act[HI:LO]), .irq_o(irq_o[g]));
  end

  p_all_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> (irq_o == '0));
  p_mask_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == A_MASK) |=> $stable(mask_q));
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == A_CFG_LO) |=> $stable(cfg_lo_q));
  p_hi_top_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CFG_HI) |-> (rdata_o[DATA_W-1:HI_BITS] == '0));
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  localparam int N = 28;

  logic        clk = 0, rst_n = 0;
  logic [N-1:0] line = '0;
  logic        sel = 0, we = 0;
  logic [1:0]  addr = 2'd3;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // cycle model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_prev, m_pend, m_mask;
  logic [31:0]  m_lo, m_hi;

  function automatic logic [2:0] m_field(int n, logic [31:0] lo, logic [31:0] hi);
    return (n < 16) ? lo[(n / 2) * 4 +: 3] : hi[((n - 16) / 2) * 4 +: 3];
  endfunction

  function automatic logic m_hit(logic [2:0] f, logic c, logic p);
    if (f == 3'b000) return !c;
    if (f == 3'b001) return c;
    if (f[2:1] == 2'b01) return p && !c;
    if (f[2:1] == 2'b10) return !p && c;
    return p != c;
  endfunction

  function automatic logic [3:0] m_groups(logic [N-1:0] p, logic [N-1:0] m);
    logic [N-1:0] a = p & ~m;
    return {|a[27:20], |a[19:12], |a[11:4], |a[3:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
      m_mask <= '1; m_lo <= '0; m_hi <= '0;
    end else begin
      logic [N-1:0] set, c;
      for (int n = 0; n < N; n++) set[n] = m_hit(m_field(n, m_lo, m_hi), m_s2[n], m_prev[n]);
      c = (sel && we && addr == 2'd3) ? wdata[N-1:0] : '0;
      m_pend <= (m_pend & ~c) | set;
      m_s1 <= line; m_s2 <= m_s1; m_prev <= m_s2;
      if (sel && we && addr == 2'd0) m_lo <= wdata;
      if (sel && we && addr == 2'd1) m_hi <= {8'h0, wdata[23:0]};
      if (sel && we && addr == 2'd2) m_mask <= wdata[N-1:0];
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0; addr = 2'd3;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = 2'd3; #1;
  endtask

  task automatic wait_neg(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int r;
    r = $urandom(32'd20250);
    #12;
    // R1 reset state
    rd(2'd2, d); check("R1 mask", d, 32'h0FFF_FFFF);
    rd(2'd3, d); check("R1 pend", d, 0);
    rd(2'd0, d); check("R1 cfg_lo", d, 0);
    rd(2'd1, d); check("R1 cfg_hi", d, 0);
    check("R1 irq", {28'h0, irq}, 0);
    rst_n = 1;
    // R2 upper mode register width, R11 mask width
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R2 cfg_hi top bits", d, 32'h00FF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); check("R11 mask top bits", d, 32'h0FFF_FFFF);
    // all lines rising (code 100), clear
    wr(2'd0, 32'h4444_4444); wr(2'd1, 32'h0044_4444);
    wr(2'd3, 32'h0FFF_FFFF);
    rd(2'd0, d); check("R2 cfg_lo readback", d, 32'h4444_4444);
    rd(2'd3, d); check("R7 clear all", d, 0);
    // R5 latency on line 5
    @(negedge clk); line[5] = 1;
    wait_neg(2); rd(2'd3, d); check("R5 not yet after two edges", d, 0);
    wait_neg(1); rd(2'd3, d); check("R5 set at third edge", d, 32'h20);
    check("R9 masked line quiet", {28'h0, irq}, 0);
    wr(2'd2, 32'h0FFF_FFDF); check("R10 group1 from line5", {28'h0, irq}, 4'b0010);
    // R7 zero bits have no effect, one bits clear
    wr(2'd3, 32'h0); rd(2'd3, d); check("R7 zero write", d, 32'h20);
    wr(2'd3, 32'h20); rd(2'd3, d); check("R7 one write", d, 0);
    check("R10 group cleared", {28'h0, irq}, 0);
    // R6 R8 high level on line 20 (field 2 of upper register)
    wr(2'd1, 32'h0044_4144);
    @(negedge clk); line[20] = 1;
    wait_neg(3); rd(2'd3, d); check("R6 level set", d, 32'h0010_0000);
    wr(2'd3, 32'h0010_0000); rd(2'd3, d); check("R8 set beats clear", d, 32'h0010_0000);
    @(negedge clk); line[20] = 0;
    wait_neg(4);
    wr(2'd3, 32'h0010_0000); rd(2'd3, d); check("R6 clear once inactive", d, 0);
    // R3 R4 falling on shared field of lines 0/1, bit 3 set (1010)
    wr(2'd0, 32'h4444_444A);
    @(negedge clk); line[1] = 1;
    wait_neg(4); rd(2'd3, d); check("R4 falling ignores rise", d, 0);
    line[1] = 0;
    wait_neg(3); rd(2'd3, d); check("R3 shared field falling line1", d, 32'h2);
    wr(2'd2, 32'h0); check("R10 group0", {28'h0, irq}, 4'b0001);
    // R9 pending regardless of mask, model check
    check("R9 model agrees", {28'h0, m_groups(m_pend, m_mask)}, {28'h0, irq});
    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      check("R10 random irq", {28'h0, irq}, {28'h0, m_groups(m_pend, m_mask)});
      if (!we) check("R5 random pend", rdata, {4'h0, m_pend});
      sel = 0; we = 0; addr = 2'd3;
      line = line ^ ($urandom & $urandom & $urandom & 28'hFFF_FFFF);
      if ($urandom_range(0, 5) == 0) begin
        sel = 1; we = 1; addr = 2'($urandom_range(0, 3)); wdata = $urandom;
      end
    end
    @(negedge clk); sel = 0; we = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule